// File: doc/BRIEF.md
# One-Time-Programmable Register Bank Controller

The block is the write-once register area behind a parallel flash command port. A host issues two-cycle program sequences on a synchronous write port. The first cycle carries a command code. The second carries a 16-bit data word. Data words land in a 128-bit identifier register and in sixteen 128-bit user registers. The lower half of the identifier register holds a unique ID that is loaded from a parameter at reset and can never be changed. Two lock registers protect the rest. Each lock bit, once cleared, stays cleared. A program operation can only clear bits: the stored word becomes the old word ANDed with the new data.

Command handling is a four-state machine:
- `ST_IDLE` waits for a command.
  - A program-data command moves it to `ST_OTP_DATA`.
  - A program-lock command moves it to `ST_LOCK_DATA`.
  - A clear-status command clears the error bits and stays in `ST_IDLE`.
  - Any other write is dropped and the state stays `ST_IDLE`.
- `ST_OTP_DATA` and `ST_LOCK_DATA` wait for the data cycle, then go to `ST_BUSY`.
- `ST_BUSY` holds the ready bit low for `BUSY_CYCLES` cycles and ignores every write, then returns to `ST_IDLE`.

A separate read port returns data words and lock registers one cycle after a request. The status byte is always visible on its own output.

Word address map:

| Address | Contents |
|---|---|
| 0x80 | lock register 0 |
| 0x81–0x84 | unique ID (read-only) |
| 0x85–0x88 | user half of the identifier register |
| 0x89 | lock register 1 |
| 0x8A + 8·n + w | word w of user register n |

Top module: `otp_bank_ctrl`

## Requirements
- R1: After reset, the following values hold:
  - status_o reads 0x80 (ready, no errors).
  - Lock register 0 reads 0xFFFE and lock register 1 reads 0xFFFF.
  - Words 0x81..0x84 hold UID_INIT, least significant 16 bits at 0x81.
  - Every other data word reads 0xFFFF.
- R2: The program sequence works as follows:
  - Writing command 0x00C0 at an address, then writing a data word, programs that word.
  - The address is taken from the command cycle.
  - The stored word becomes old AND data, so bits only go from 1 to 0.
- R3: Ready (status bit 7) timing:
  - Ready goes low in the cycle after the data cycle and stays low for exactly BUSY_CYCLES cycles.
  - Writes issued while ready is low are ignored.
- R4: A 0x00C0 sequence outside the data ranges sets status bit 4 only and changes no stored word.
  - The data ranges are 0x81–0x88 and 0x8A–0x109.
  - The lock addresses 0x80 and 0x89 count as outside.
- R5: Words 0x81–0x84 are always locked. Programming them sets status bits 4 and 1 and leaves them unchanged.
- R6: Locking the user half of the identifier register:
  - Command 0x00C1 at 0x80 followed by data 0xFFFD clears bit 1 of lock register 0.
  - After that, words 0x85–0x88 are locked: programming one sets bits 4 and 1 and leaves it unchanged.
- R7: Clearing bit n of lock register 1 (command 0x00C1 at 0x89) locks words 0x8A+8n .. 0x8A+8n+7. Other user registers stay programmable.
- R8: Lock register behaviour:
  - Lock registers are ANDed with the written data, so a cleared lock bit never returns to 1.
  - A 0x00C1 sequence at any address other than 0x80 or 0x89 sets status bit 4.
- R9: Status bits 4 and 1 stay set until command 0x0050 is written while idle. That command clears both.
- R10: Read port behaviour:
  - rd_valid and rd_data appear one cycle after rd_en.
  - Data words and lock registers read back their stored values.
  - Unmapped addresses read 0x0000.
- R11: A write in ST_IDLE whose data is not 0x00C0, 0x00C1 or 0x0050 is ignored. The next write is then treated as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write cycle strobe |
| wr_addr | input | 9 | Word address of the write cycle |
| wr_data | input | 16 | Command code or program data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 9 | Word address to read |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | rd_data is valid this cycle |
| status_o | output | 8 | Bit 7 ready, bit 4 program error, bit 1 lock error |

## Verification
The hardest situation to reach from the ports is a lock error on a user register that was written successfully before its lock bit was cleared. The stimulus first programs a word in user register 3 and then clears bit 3 of lock register 1. It then programs the same word again and expects the error pair with the word unchanged. A word in register 4 is programmed afterwards to show that the neighbouring register is still open. Writes landing inside the busy window are placed right after a data cycle, before ready returns. A stray data word is then sent while idle, which proves that neither write reached a register.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [1:0] {
        ADR_NONE,
        ADR_LOCK0,
        ADR_LOCK1,
        ADR_DATA
    } adr_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OTP_DATA,
        ST_LOCK_DATA,
        ST_BUSY
    } fsm_st_e;

    localparam logic [7:0] CMD_OTP_PROG  = 8'hC0;
    localparam logic [7:0] CMD_LOCK_PROG = 8'hC1;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;

    localparam int STAT_W    = 8;
    localparam int STAT_RDY  = 7;
    localparam int STAT_PERR = 4;
    localparam int STAT_LERR = 1;

endpackage

// File: rtl/otp_addr_decode.sv
module otp_addr_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W        = 9,
    parameter int BASE_OFF      = 128,
    parameter int WORDS_PER_REG = 8,
    parameter int USER_REGS     = 16,
    parameter int IDX_W         = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output adr_cls_e          cls,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W-1:0] A_LK0 = ADDR_W'(BASE_OFF);
    localparam logic [ADDR_W-1:0] A_LK1 = ADDR_W'(BASE_OFF + 1 + WORDS_PER_REG);
    localparam logic [ADDR_W-1:0] A_USR = ADDR_W'(BASE_OFF + 2 + WORDS_PER_REG);
    localparam logic [ADDR_W-1:0] A_END = ADDR_W'(BASE_OFF + 2 + WORDS_PER_REG
                                                  + USER_REGS * WORDS_PER_REG);
    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_WPR = ADDR_W'(WORDS_PER_REG);

    always_comb begin
        cls = ADR_NONE;
        idx = '0;
        if (addr == A_LK0) begin
            cls = ADR_LOCK0;
        end else if (addr == A_LK1) begin
            cls = ADR_LOCK1;
        end else if (addr > A_LK0 && addr < A_LK1) begin
            cls = ADR_DATA;
            idx = IDX_W'(addr - A_LK0 - A_ONE);
        end else if (addr >= A_USR && addr < A_END) begin
            cls = ADR_DATA;
            idx = IDX_W'(addr - A_USR + A_WPR);
        end
    end

endmodule

// File: rtl/otp_store.sv
module otp_store
    import otp_pkg::*;
#(
    parameter int WORD_W        = 16,
    parameter int WORDS_PER_REG = 8,
    parameter int USER_REGS     = 16,
    parameter int IDX_W         = 8,
    parameter int TOTAL_WORDS   = 136,
    parameter logic [WORDS_PER_REG/2*WORD_W-1:0] UID_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [WORD_W-1:0] prog_data,
    input  logic              lock_we,
    input  logic              lock_sel,
    input  logic [WORD_W-1:0] lock_data,
    output logic              tgt_locked,
    input  logic              rd_en,
    input  adr_cls_e          rd_cls,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int ID_HALF = WORDS_PER_REG / 2;
    localparam int REG_SH  = $clog2(WORDS_PER_REG);
    localparam int LK_W    = (USER_REGS > 1) ? $clog2(USER_REGS) : 1;

    logic [WORD_W-1:0] mem [TOTAL_WORDS];
    logic [WORD_W-1:0] lock0_q;
    logic [WORD_W-1:0] lock1_q;
    logic [IDX_W-1:0]  rel;
    logic [LK_W-1:0]   regn;
    logic [WORD_W-1:0] tgt_word;

    function automatic logic [WORD_W-1:0] init_word(input int i);
        if (i < ID_HALF) begin
            return UID_INIT[i*WORD_W +: WORD_W];
        end
        return '1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL_WORDS; i++) begin
                mem[i] <= init_word(i);
            end
        end else if (prog_we) begin
            mem[prog_idx] <= mem[prog_idx] & prog_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock0_q <= {{(WORD_W-1){1'b1}}, 1'b0};
            lock1_q <= '1;
        end else if (lock_we) begin
            if (lock_sel) begin
                lock1_q <= lock1_q & lock_data;
            end else begin
                lock0_q <= lock0_q & lock_data;
            end
        end
    end

    always_comb begin
        rel  = prog_idx - IDX_W'(WORDS_PER_REG);
        regn = LK_W'(rel >> REG_SH);
        if (prog_idx < IDX_W'(ID_HALF)) begin
            tgt_locked = !lock0_q[0];
        end else if (prog_idx < IDX_W'(WORDS_PER_REG)) begin
            tgt_locked = !lock0_q[1];
        end else begin
            tgt_locked = !lock1_q[regn];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                unique case (rd_cls)
                    ADR_LOCK0: rd_data <= lock0_q;
                    ADR_LOCK1: rd_data <= lock1_q;
                    ADR_DATA:  rd_data <= mem[rd_idx];
                    ADR_NONE:  rd_data <= '0;
                endcase
            end
        end
    end

    assign tgt_word = mem[prog_idx];

    // R8: no lock bit ever goes back from 0 to 1
    a_r8_lock_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((lock0_q & ~$past(lock0_q)) == '0) && ((lock1_q & ~$past(lock1_q)) == '0)));

    // R5: the factory lock on the unique ID is always in force
    a_r5_uid_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
        !lock0_q[0]);

    // R2: a program operation only clears bits of the target word
    a_r2_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |=> ((tgt_word & ~$past(tgt_word)) == '0));

endmodule

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
    import otp_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int WORD_W      = 16,
    parameter int BUSY_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  adr_cls_e          tgt_cls,
    input  logic              tgt_locked,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic              prog_we,
    output logic              lock_we,
    output logic              lock_sel,
    output logic [STAT_W-1:0] status_o
);

    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0]  CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);
    localparam logic [WORD_W-1:0] C_OTP    = WORD_W'(CMD_OTP_PROG);
    localparam logic [WORD_W-1:0] C_LOCK   = WORD_W'(CMD_LOCK_PROG);
    localparam logic [WORD_W-1:0] C_CLR    = WORD_W'(CMD_CLR_STAT);

    fsm_st_e           state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] tgt_addr_q;
    logic              perr_q, lerr_q;
    logic              set_perr, set_lerr, clr_hit, cap_addr;
    logic              lock_addr_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en && wr_data == C_OTP) begin
                    state_d = ST_OTP_DATA;
                end else if (wr_en && wr_data == C_LOCK) begin
                    state_d = ST_LOCK_DATA;
                end
            end
            ST_OTP_DATA:  if (wr_en) state_d = ST_BUSY;
            ST_LOCK_DATA: if (wr_en) state_d = ST_BUSY;
            ST_BUSY:      if (cnt_q == '0) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        prog_we      = 1'b0;
        lock_we      = 1'b0;
        set_perr     = 1'b0;
        set_lerr     = 1'b0;
        clr_hit      = 1'b0;
        cap_addr     = 1'b0;
        lock_addr_ok = (tgt_cls == ADR_LOCK0) || (tgt_cls == ADR_LOCK1);
        lock_sel     = (tgt_cls == ADR_LOCK1);
        unique case (state_q)
            ST_IDLE: begin
                cap_addr = wr_en && (wr_data == C_OTP || wr_data == C_LOCK);
                clr_hit  = wr_en && (wr_data == C_CLR);
            end
            ST_OTP_DATA: begin
                if (wr_en) begin
                    if (tgt_cls != ADR_DATA) begin
                        set_perr = 1'b1;
                    end else if (tgt_locked) begin
                        set_perr = 1'b1;
                        set_lerr = 1'b1;
                    end else begin
                        prog_we = 1'b1;
                    end
                end
            end
            ST_LOCK_DATA: begin
                if (wr_en) begin
                    lock_we  = lock_addr_ok;
                    set_perr = !lock_addr_ok;
                end
            end
            ST_BUSY: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_addr_q <= '0;
            cnt_q      <= '0;
            perr_q     <= 1'b0;
            lerr_q     <= 1'b0;
        end else begin
            if (cap_addr) begin
                tgt_addr_q <= wr_addr;
            end
            if (state_q != ST_BUSY && state_d == ST_BUSY) begin
                cnt_q <= CNT_LOAD;
            end else if (state_q == ST_BUSY && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (clr_hit) begin
                perr_q <= 1'b0;
                lerr_q <= 1'b0;
            end else begin
                if (set_perr) perr_q <= 1'b1;
                if (set_lerr) lerr_q <= 1'b1;
            end
        end
    end

    assign tgt_addr = tgt_addr_q;

    always_comb begin
        status_o            = '0;
        status_o[STAT_RDY]  = (state_q != ST_BUSY);
        status_o[STAT_PERR] = perr_q;
        status_o[STAT_LERR] = lerr_q;
    end

    // R3: ready drops in the cycle after any data cycle
    a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_OTP_DATA || state_q == ST_LOCK_DATA) && wr_en) |=> !status_o[STAT_RDY]);

    // R3: nothing is written while busy
    a_r3_busy_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |-> (!prog_we && !lock_we));

    // R9: a program error stays set unless a clear command arrives while idle
    a_r9_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[STAT_PERR] && !(state_q == ST_IDLE && wr_en && wr_data == C_CLR))
        |=> status_o[STAT_PERR]);

    // R5: a lock error is never reported without a program error
    a_r5_lerr_with_perr: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[STAT_LERR] |-> status_o[STAT_PERR]);

endmodule

// File: rtl/otp_bank_ctrl.sv
module otp_bank_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W        = 9,
    parameter int WORD_W        = 16,
    parameter int USER_REGS     = 16,
    parameter int WORDS_PER_REG = 8,
    parameter int BASE_OFF      = 128,
    parameter int BUSY_CYCLES   = 3,
    parameter logic [WORDS_PER_REG/2*WORD_W-1:0] UID_INIT = 64'h1234_5678_9ABC_DEF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [STAT_W-1:0] status_o
);

    localparam int TOTAL_WORDS = WORDS_PER_REG * (USER_REGS + 1);
    localparam int IDX_W       = $clog2(TOTAL_WORDS);

    logic [ADDR_W-1:0] tgt_addr;
    adr_cls_e          tgt_cls, rd_cls;
    logic [IDX_W-1:0]  tgt_idx, rd_idx;
    logic              tgt_locked;
    logic              prog_we, lock_we, lock_sel;

    otp_cmd_fsm #(
        .ADDR_W      (ADDR_W),
        .WORD_W      (WORD_W),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tgt_cls    (tgt_cls),
        .tgt_locked (tgt_locked),
        .tgt_addr   (tgt_addr),
        .prog_we    (prog_we),
        .lock_we    (lock_we),
        .lock_sel   (lock_sel),
        .status_o   (status_o)
    );

    otp_addr_decode #(
        .ADDR_W        (ADDR_W),
        .BASE_OFF      (BASE_OFF),
        .WORDS_PER_REG (WORDS_PER_REG),
        .USER_REGS     (USER_REGS),
        .IDX_W         (IDX_W)
    ) u_wdec (
        .addr (tgt_addr),
        .cls  (tgt_cls),
        .idx  (tgt_idx)
    );

    otp_addr_decode #(
        .ADDR_W        (ADDR_W),
        .BASE_OFF      (BASE_OFF),
        .WORDS_PER_REG (WORDS_PER_REG),
        .USER_REGS     (USER_REGS),
        .IDX_W         (IDX_W)
    ) u_rdec (
        .addr (rd_addr),
        .cls  (rd_cls),
        .idx  (rd_idx)
    );

    otp_store #(
        .WORD_W        (WORD_W),
        .WORDS_PER_REG (WORDS_PER_REG),
        .USER_REGS     (USER_REGS),
        .IDX_W         (IDX_W),
        .TOTAL_WORDS   (TOTAL_WORDS),
        .UID_INIT      (UID_INIT)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_we    (prog_we),
        .prog_idx   (tgt_idx),
        .prog_data  (wr_data),
        .lock_we    (lock_we),
        .lock_sel   (lock_sel),
        .lock_data  (wr_data),
        .tgt_locked (tgt_locked),
        .rd_en      (rd_en),
        .rd_cls     (rd_cls),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    // R10: a read answer follows every request by one cycle
    a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

endmodule

// File: tb/sim_otp_bank_ctrl.sv
module sim_otp_bank_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 3;
    localparam logic [63:0] UID = 64'h1234_5678_9ABC_DEF0;
    localparam logic [15:0] C_OTP  = 16'h00C0;
    localparam logic [15:0] C_LOCK = 16'h00C1;
    localparam logic [15:0] C_CLR  = 16'h0050;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [7:0]  status_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] mdl [136];
    logic [15:0] lk0, lk1;
    bit          e_perr, e_lerr;

    logic [15:0] q_val [$];
    string       q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_bank_ctrl u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .status_o (status_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read results
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q_val.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R10 unexpected read actual=%h expected=none", rd_data);
            end else begin
                check(q_tag.pop_front(), rd_data, q_val.pop_front());
            end
        end
    end

    // 0 none, 1 lock0, 2 lock1, 3 data
    function automatic int classify(input int a, output int idx);
        idx = 0;
        if (a == 'h80) return 1;
        if (a == 'h89) return 2;
        if (a >= 'h81 && a <= 'h88) begin idx = a - 'h81; return 3; end
        if (a >= 'h8A && a <= 'h109) begin idx = a - 'h8A + 8; return 3; end
        return 0;
    endfunction

    function automatic bit mdl_locked(input int idx);
        if (idx < 4) return !lk0[0];
        if (idx < 8) return !lk0[1];
        return !lk1[(idx - 8) / 8];
    endfunction

    function automatic logic [15:0] mdl_value(input int a);
        int idx;
        int c;
        c = classify(a, idx);
        if (c == 1) return lk0;
        if (c == 2) return lk1;
        if (c == 3) return mdl[idx];
        return 16'h0000;
    endfunction

    function automatic logic [7:0] exp_status();
        return 8'h80 | (e_perr ? 8'h10 : 8'h00) | (e_lerr ? 8'h02 : 8'h00);
    endfunction

    task automatic cyc_wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 9'(a);
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic exp_read(input int a, input string tag);
        q_val.push_back(mdl_value(a));
        q_tag.push_back(tag);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = 9'(a);
        @(negedge clk);
        rd_en   = 1'b0;
    endtask

    task automatic wait_ready(input string tag, input bit count_it);
        int n = 0;
        while (status_o[7] == 1'b0 && n < 50) begin
            n++;
            @(negedge clk);
        end
        if (count_it) check({tag, " R3 busy length"}, 16'(n), 16'(BUSY));
    endtask

    // driver: one program sequence plus its expected results
    task automatic prog(input bit is_lock, input int a, input logic [15:0] d, input string tag);
        int idx;
        int c;
        cyc_wr(a, is_lock ? C_LOCK : C_OTP);
        cyc_wr(a, d);
        check({tag, " R3 ready low"}, 16'(status_o[7]), 16'h0);
        c = classify(a, idx);
        if (!is_lock) begin
            if (c == 3) begin
                if (mdl_locked(idx)) begin
                    e_perr = 1'b1;
                    e_lerr = 1'b1;
                end else begin
                    mdl[idx] = mdl[idx] & d;
                end
            end else begin
                e_perr = 1'b1;
            end
        end else begin
            if (c == 1) lk0 = lk0 & d;
            else if (c == 2) lk1 = lk1 & d;
            else e_perr = 1'b1;
        end
        wait_ready(tag, 1'b1);
        check({tag, " status"}, 16'(status_o), 16'(exp_status()));
        exp_read(a, {tag, " readback"});
    endtask

    task automatic clear_status(input string tag);
        cyc_wr('h81, C_CLR);
        e_perr = 1'b0;
        e_lerr = 1'b0;
        check({tag, " status cleared"}, 16'(status_o), 16'h0080);
    endtask

    initial begin
        for (int i = 0; i < 136; i++) mdl[i] = (i < 4) ? UID[i*16 +: 16] : 16'hFFFF;
        lk0 = 16'hFFFE;
        lk1 = 16'hFFFF;
        e_perr = 1'b0;
        e_lerr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 reset status", 16'(status_o), 16'h0080);
        exp_read('h80, "R1 lock0 reset");
        exp_read('h89, "R1 lock1 reset");
        for (int a = 'h81; a <= 'h84; a++) exp_read(a, "R1 uid word");
        exp_read('h85, "R1 erased id upper");
        exp_read('h109, "R1 erased last user word");
        // R10 unmapped
        exp_read('h7F, "R10 unmapped below");
        exp_read('h10A, "R10 unmapped above");

        // R2 programming and AND behaviour
        prog(1'b0, 'h85, 16'hA5F0, "R2 first program");
        prog(1'b0, 'h85, 16'h0F0F, "R2 and program");

        // R3 writes during busy ignored, R11 stray data ignored
        cyc_wr('h86, C_OTP);
        cyc_wr('h86, 16'h00F0);
        mdl[5] = mdl[5] & 16'h00F0;
        cyc_wr('h87, C_OTP);
        wait_ready("R3 busy", 1'b0);
        cyc_wr('h87, 16'h0000);
        check("R11 stray data status", 16'(status_o), 16'h0080);
        exp_read('h87, "R3 R11 busy write ignored");
        exp_read('h86, "R2 second word");

        // R5 unique ID locked
        prog(1'b0, 'h82, 16'h0000, "R5 uid write");
        // R9 sticky errors across a good program
        prog(1'b0, 'h88, 16'h00FF, "R9 sticky");
        clear_status("R9");

        // R4 out of range
        prog(1'b0, 'h7F, 16'h0000, "R4 below");
        clear_status("R4");
        prog(1'b0, 'h80, 16'h0000, "R4 lock0 addr");
        clear_status("R4");
        prog(1'b0, 'h10A, 16'h0000, "R4 above");
        clear_status("R4");
        prog(1'b0, 'h109, 16'h0000, "R2 last user word");

        // R6 lock user half of id register
        prog(1'b1, 'h80, 16'hFFFD, "R6 set lock");
        prog(1'b0, 'h86, 16'h0000, "R6 locked write");
        clear_status("R6");

        // R7 lock user register 3
        prog(1'b0, 'hA4, 16'h00AA, "R7 before lock");
        prog(1'b1, 'h89, 16'hFFF7, "R7 set lock");
        prog(1'b0, 'hA4, 16'h0000, "R7 locked write");
        clear_status("R7");
        prog(1'b0, 'hAA, 16'h1111, "R7 neighbour open");

        // R8 no unlock, bad lock address
        prog(1'b1, 'h89, 16'hFFFF, "R8 no unlock");
        prog(1'b1, 'h85, 16'h0000, "R8 bad lock addr");
        clear_status("R8");

        // R11 unknown command then a data word in idle
        cyc_wr('h8B, 16'h00FF);
        cyc_wr('h8B, 16'h0000);
        check("R11 unknown cmd status", 16'(status_o), 16'h0080);
        exp_read('h8B, "R11 unknown cmd no write");

        repeat (4) @(negedge clk);
        if (q_val.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R10 missing reads actual=%0d expected=0", q_val.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule